// File: doc/BRIEF.md
# Single-Word Peripheral-to-Memory Mover

This block is a one-channel direct memory access engine. It copies a single data word from a peripheral register into data memory each time the peripheral raises its service line. Before any move, the processor loads a source address and a destination address through a small configuration port. No interrupt service routine is involved in a move.

A move uses two nested handshakes. On a peripheral request, the engine first asks the processor for the system bus and then waits. The processor hands the bus over only at an instruction boundary and keeps executing while it does not need the bus. Once the bus is granted, the engine raises its acknowledge to the peripheral. It then performs one bus read from the source and one bus write of the captured word to the destination. After that it drops both its bus request and its acknowledge. A new move is accepted only after the peripheral has taken its request away. The configuration port can also be read back, and it exposes a busy flag and a count of completed moves.

Top module: `dmaMover`

## Requirements
- R1: After reset, busReq, periphAck, busRd and busWr are low, and the source address, destination address and completed-move count all read as zero.
- R2: A configuration write with cfgAddr 0 loads the source address and one with cfgAddr 1 loads the destination address. A read with cfgAddr 0 or 1 returns the stored value, cfgAddr 3 returns zero, and cfgAddr 2 returns the status word: bit 15 is busy and bits 7:0 are the completed-move count.
- R3: An idle engine that samples periphReq high raises busReq on the next cycle. It keeps busRd and busWr low for as long as busGrant is not sampled high.
- R4: The cycle after busGrant is sampled high while busReq is raised, the engine drives busRd for exactly one cycle with busAddr equal to the source address, and periphAck is high.
- R5: The word present on busRdData in the cycle after the read strobe is captured. In the following cycle it is driven on busWrData with busWr high for one cycle and busAddr equal to the destination address.
- R6: On the cycle after the write strobe, busReq and periphAck are both low and the completed-move count has risen by one.
- R7: While periphReq stays high after a move has finished, no further bus request is made. A new move starts only after periphReq has been low for at least one cycle.
- R8: busGrant sampled high while no move is pending has no effect: busReq, busRd and busWr stay low.
- R9: The busy flag is high from the cycle in which busReq rises until the engine is idle again, which is after the move has finished and periphReq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| periphReq | input | 1 | Service request from the peripheral |
| periphAck | output | 1 | Acknowledge to the peripheral while the bus is held |
| busReq | output | 1 | Bus request to the processor |
| busGrant | input | 1 | Bus grant from the processor |
| busAddr | output | ADDR_W (16) | Bus address |
| busRd | output | 1 | Bus read strobe |
| busWr | output | 1 | Bus write strobe |
| busRdData | input | DATA_W (8) | Read data, valid the cycle after busRd |
| busWrData | output | DATA_W (8) | Write data, valid with busWr |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 2 | Configuration register index |
| cfgWrData | input | ADDR_W (16) | Configuration write value |
| cfgRdData | output | ADDR_W (16) | Configuration read value for cfgAddr |

## Verification
Each result has a fixed delay from its stimulus. busReq follows a sampled request by one cycle. The read strobe follows a sampled grant by one cycle. The data capture comes one cycle after the read strobe, and the write comes one cycle after that. The release and the count increment come one cycle after the write. The bench keeps its own phase model, advanced on every rising edge from the inputs it drives. On every falling edge it compares all outputs, including the status word, with that model, so each result is checked in the exact cycle it is due. The bench returns valid read data only in the capture cycle, so capturing one cycle early or late shows up at the write data.

// File: rtl/dmaMoverPkg.sv
package dmaMoverPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ASK, ST_READ, ST_LATCH, ST_WRITE, ST_DRAIN
  } moverStateT;

  typedef struct packed {
    logic useDst;
    logic loadHold;
    logic bumpCount;
  } pathCtrlT;

  localparam logic [1:0] CFG_SRC    = 2'd0;
  localparam logic [1:0] CFG_DST    = 2'd1;
  localparam logic [1:0] CFG_STATUS = 2'd2;
endpackage

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaMoverPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     periphReq,
  input  logic     busGrant,
  output logic     busReq,
  output logic     periphAck,
  output logic     busRd,
  output logic     busWr,
  output logic     busy,
  output pathCtrlT pathCtrl
);
  moverStateT state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (periphReq) stateNext = ST_ASK;
      ST_ASK:   if (busGrant)  stateNext = ST_READ;
      ST_READ:  stateNext = ST_LATCH;
      ST_LATCH: stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_DRAIN;
      ST_DRAIN: if (!periphReq) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    busReq    = (state == ST_ASK) || (state == ST_READ) ||
                (state == ST_LATCH) || (state == ST_WRITE);
    periphAck = (state == ST_READ) || (state == ST_LATCH) || (state == ST_WRITE);
    busRd     = (state == ST_READ);
    busWr     = (state == ST_WRITE);
    busy      = (state != ST_IDLE);
    pathCtrl.useDst    = (state == ST_WRITE);
    pathCtrl.loadHold  = (state == ST_LATCH);
    pathCtrl.bumpCount = (state == ST_WRITE);
  end
endmodule

// File: rtl/dmaPath.sv
module dmaPath
  import dmaMoverPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtrlT          pathCtrl,
  input  logic              busy,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [DATA_W-1:0] busRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic [ADDR_W-1:0] cfgRdData
);
  localparam int PAD_W = ADDR_W - 1 - CNT_W;

  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [DATA_W-1:0] holdWord;
  logic [CNT_W-1:0]  doneCount;
  logic [ADDR_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == CFG_SRC) srcAddr <= cfgWrData;
      if (cfgAddr == CFG_DST) dstAddr <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdWord <= '0;
    else if (pathCtrl.loadHold) holdWord <= busRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneCount <= '0;
    else if (pathCtrl.bumpCount) doneCount <= doneCount + 1'b1;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign statusWord = {busy, {PAD_W{1'b0}}, doneCount};
    end else begin : g_nopad
      assign statusWord = {busy, doneCount[ADDR_W-2:0]};
    end
  endgenerate

  assign busAddr   = pathCtrl.useDst ? dstAddr : srcAddr;
  assign busWrData = holdWord;

  always_comb begin
    unique case (cfgAddr)
      CFG_SRC:    cfgRdData = srcAddr;
      CFG_DST:    cfgRdData = dstAddr;
      CFG_STATUS: cfgRdData = statusWord;
      default:    cfgRdData = '0;
    endcase
  end
endmodule

// File: rtl/dmaMover.sv
module dmaMover
  import dmaMoverPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periphReq,
  output logic              periphAck,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  input  logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] busWrData,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  output logic [ADDR_W-1:0] cfgRdData
);
  pathCtrlT pathCtrl;
  logic     busy;

  dmaCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .periphReq(periphReq), .busGrant(busGrant),
    .busReq(busReq), .periphAck(periphAck), .busRd(busRd), .busWr(busWr),
    .busy(busy), .pathCtrl(pathCtrl)
  );

  dmaPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .pathCtrl(pathCtrl), .busy(busy),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .busRdData(busRdData), .busAddr(busAddr), .busWrData(busWrData),
    .cfgRdData(cfgRdData)
  );
endmodule

// File: rtl/dmaMoverChk.sv
module dmaMoverChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              periphAck,
  input logic              busReq,
  input logic              busGrant,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busRdData,
  input logic [DATA_W-1:0] busWrData
);
  // R3: bus strobes only while the bus is requested
  a_r3_strobe_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> busReq);

  // R4: a read follows a sampled grant, with the peripheral acknowledged
  a_r4_read_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRd) |-> ($past(busGrant) && periphAck));

  // R4: single-cycle read strobe
  a_r4_read_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> (!busRd && !busWr));

  // R5: the write comes two cycles after the read
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> $past(busRd, 2));

  // R5: the written word is the one returned in the cycle after the read
  a_r5_write_data: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> (busWrData == $past(busRdData)));

  // R6: release of both handshakes after the write
  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> (!busReq && !periphAck));

  // R6: acknowledge never without the bus request
  a_r6_ack_nested: assert property (@(posedge clk) disable iff (!rstN)
    periphAck |-> busReq);
endmodule

bind dmaMover dmaMoverChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .periphAck(periphAck), .busReq(busReq),
  .busGrant(busGrant), .busRd(busRd), .busWr(busWr),
  .busRdData(busRdData), .busWrData(busWrData)
);

// File: tb/sim_dmaMover.sv
module sim_dmaMover;
  localparam int CLK_PERIOD = 10;
  localparam int WATCH_LIMIT = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        periphReq = 1'b0;
  logic        periphAck;
  logic        busReq;
  logic        busGrant = 1'b0;
  logic [15:0] busAddr;
  logic        busRd, busWr;
  logic [7:0]  busRdData;
  logic [7:0]  busWrData;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = 2'd2;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference: phase 0 idle, 1 asking, 2 read, 3 capture, 4 write, 5 drain
  int          mPhase = 0;
  logic [15:0] mSrc = '0, mDst = '0;
  logic [7:0]  mHold = '0;
  int          mCount = 0;
  logic [7:0]  perVal = 8'h00;

  assign busRdData = (mPhase == 3) ? perVal : ~perVal;

  dmaMover u0 (
    .clk(clk), .rstN(rstN), .periphReq(periphReq), .periphAck(periphAck),
    .busReq(busReq), .busGrant(busGrant), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busRdData(busRdData), .busWrData(busWrData),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mSrc = '0; mDst = '0; mHold = '0; mCount = 0;
    end else begin
      if (cfgWe && cfgAddr == 2'd0) mSrc = cfgWrData;
      if (cfgWe && cfgAddr == 2'd1) mDst = cfgWrData;
      case (mPhase)
        0: if (periphReq) mPhase = 1;
        1: if (busGrant) mPhase = 2;
        2: mPhase = 3;
        3: begin mHold = busRdData; mPhase = 4; end
        4: begin mCount = (mCount + 1) % 256; mPhase = 5; end
        default: if (!periphReq) mPhase = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic compareAll();
    logic [15:0] expCfg;
    bit eReq, eAck;
    string reqTag;
    eReq = (mPhase >= 1 && mPhase <= 4);
    eAck = (mPhase >= 2 && mPhase <= 4);
    reqTag = (mPhase == 5) ? "R6 busReq released" :
             (mPhase == 0 && busGrant) ? "R8 busReq with idle grant" : "R3 busReq";
    chk(busReq == eReq, reqTag, busReq, eReq);
    chk(periphAck == eAck, (mPhase == 5) ? "R6 periphAck released" : "R4 periphAck", periphAck, eAck);
    chk(busRd == (mPhase == 2), "R4 busRd", busRd, mPhase == 2);
    chk(busWr == (mPhase == 4), "R5 busWr", busWr, mPhase == 4);
    if (mPhase == 2) chk(busAddr == mSrc, "R4 read address", busAddr, mSrc);
    if (mPhase == 4) begin
      chk(busAddr == mDst, "R5 write address", busAddr, mDst);
      chk(busWrData == mHold, "R5 write data", busWrData, mHold);
    end
    case (cfgAddr)
      2'd0: expCfg = mSrc;
      2'd1: expCfg = mDst;
      2'd2: expCfg = {(mPhase != 0), 7'd0, 8'(mCount)};
      default: expCfg = '0;
    endcase
    chk(cfgRdData == expCfg, (cfgAddr == 2'd2) ? "R9 status word" : "R2 cfg readback", cfgRdData, expCfg);
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic cfgWrite(input logic [1:0] idx, input logic [15:0] val);
    cfgAddr = idx; cfgWrData = val; cfgWe = 1'b1;
    tick();
    cfgWe = 1'b0; cfgAddr = 2'd2;
  endtask

  task automatic doMove(input logic [7:0] val, input int gDelay, input int holdAfter, input bit earlyGrant);
    perVal = val;
    busGrant = earlyGrant;
    periphReq = 1'b1;
    while (mPhase != 1) tick();
    for (int i = 0; i < gDelay; i++) tick();
    busGrant = 1'b1;
    while (mPhase != 5) tick();
    busGrant = 1'b0;
    for (int i = 0; i < holdAfter; i++) begin
      tick();
      chk(busReq == 1'b0, "R7 no repeat while request held", busReq, 0);
    end
    periphReq = 1'b0;
    while (mPhase != 0) tick();
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCH_LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCH_LIMIT);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    chk(busReq == 0 && periphAck == 0 && busRd == 0 && busWr == 0, "R1 idle strobes",
        {busReq, periphAck, busRd, busWr}, 0);
    chk(cfgRdData == 16'h0, "R1 status zero", cfgRdData, 0);
    rstN = 1'b1;
    tick();
    cfgAddr = 2'd0; tick(); chk(cfgRdData == 16'h0, "R1 source zero", cfgRdData, 0);
    cfgAddr = 2'd1; tick(); chk(cfgRdData == 16'h0, "R1 destination zero", cfgRdData, 0);
    cfgAddr = 2'd2;

    // R2: configuration
    cfgWrite(2'd0, 16'h8000);
    cfgWrite(2'd1, 16'h0001);
    cfgAddr = 2'd0; tick(); chk(cfgRdData == 16'h8000, "R2 source readback", cfgRdData, 16'h8000);
    cfgAddr = 2'd1; tick(); chk(cfgRdData == 16'h0001, "R2 destination readback", cfgRdData, 16'h0001);
    cfgAddr = 2'd3; tick(); chk(cfgRdData == 16'h0, "R2 spare index", cfgRdData, 0);
    cfgAddr = 2'd2;

    // R8: grant with nothing pending
    busGrant = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(busReq == 0 && busRd == 0 && busWr == 0, "R8 idle grant ignored", {busReq, busRd, busWr}, 0);
    end
    busGrant = 1'b0;
    tick();

    // R3 R4 R5 R6 R7: delayed grant, request held long after the move
    doMove(8'h5A, 3, 5, 1'b0);
    chk(cfgRdData == 16'h0001, "R6 count after first move", cfgRdData, 16'h0001);
    // grant already present when the request comes
    doMove(8'hC3, 0, 0, 1'b1);
    // new addresses, request dropped mid-move
    cfgWrite(2'd0, 16'h1234);
    cfgWrite(2'd1, 16'h00FF);
    perVal = 8'h0F;
    periphReq = 1'b1;
    while (mPhase != 1) tick();
    busGrant = 1'b1;
    while (mPhase != 2) tick();
    periphReq = 1'b0;
    while (mPhase != 5) tick();
    busGrant = 1'b0;
    tick(); tick();
    chk(cfgRdData == 16'h0003, "R9 idle with count three", cfgRdData, 16'h0003);
    finishRun();
  end
endmodule